// File: doc/BRIEF.md
# Dual-Sequencer ADC Conversion Controller

This controller schedules conversions for an analog-to-digital converter through two independent sequencers, A and B. Each sequencer walks its own list of channel slots. A holds slots 0 to 7 and B holds slots 8 to 15. Each list is as long as its programmed count field plus one. Either sequencer starts from an external trigger pulse, gated by its own enable, or from a software start bit in a shared control register.

For every slot, the controller holds the sample-and-hold window open for a programmed number of clocks. It then pulses a start strobe to the converter, waits for the converter's done pulse, and stores the returned sample in that slot's result register. When a list is finished, the sequencer stops and waits for the next request. It also raises its end-of-sequence flag if that sequencer's interrupt is enabled.

The pending-start bits are write-1-to-set and read back as zero at the control address. A CPU read-modify-write of that register therefore cannot replay a start that the hardware has already consumed. It also cannot cancel a start that hardware has just raised on the other sequencer. Reset is asynchronous and active low, and its release must already be synchronous to `clk`.

Top module: `adc_dualseq_ctrl`

## Requirements
- R1: After reset, these are all zero: the status word, both interrupt outputs, `conv_sample`, `conv_start`, and every result register.
- R2: Writing 1 to control bit 0 (sequencer A) or bit 1 (sequencer B) at address 0 requests a start. Control bits 0, 1, 6 and 7 always read as 0. The request shows in status (address 1): bits 1:0 are pending B:A, bits 3:2 are flag B:A, bits 5:4 are busy B:A, and bit 6 is converter busy.
- R3: Writing 0 to a start bit has no effect. A pending bit survives a CPU write of the other control bits, including one in the same cycle as the trigger that sets it.
- R4: An external trigger (`trig_a`, `trig_b`) sets its sequencer's pending bit only while that sequencer's trigger enable is 1. The enables are control bit 2 for A and bit 3 for B. With its enable at 0, a trigger is ignored.
- R5: If a CPU set and the hardware clear at grant land in the same cycle, the set wins, and the sequencer runs once more.
- R6: A run converts length+1 slots. Address 2 holds the length fields, with A in bits 2:0 and B in bits 10:8. Sequencer A uses slots 0 to length and sequencer B uses slots 8 to 8+length. The channel for slot s is nibble s mod 4 of address 4 + s/4.
- R7: Before each one-cycle `conv_start` pulse, `conv_sample` is high for exactly ACQ+1 consecutive cycles, where ACQ is held in address 3, bits 3:0.
- R8: After the last slot, the controller stays idle and issues no conversion until a new request arrives.
- R9: When both sequencers are pending while the converter is idle, A is granted first. B starts when A's run ends.
- R10: Any number of requests arriving while a sequencer is busy produce exactly one extra run of that sequencer.
- R11: `conv_data`, captured on `conv_done`, is stored as the result of the current slot s. It is readable, zero-extended, at address 16+s.
- R12: At the end of a run, the sequencer's flag and interrupt output are set only if its interrupt enable is 1. The enables are control bit 4 for A and bit 5 for B. Writing 1 to control bit 6 (A) or bit 7 (B) clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| trig_a | input | 1 | External start pulse for sequencer A |
| trig_b | input | 1 | External start pulse for sequencer B |
| conv_sample | output | 1 | Sample-and-hold window open |
| conv_start | output | 1 | One-cycle conversion start strobe |
| conv_chan | output | 4 | Channel of the slot being converted |
| conv_done | input | 1 | Converter result-valid pulse |
| conv_data | input | 12 | Converter result |
| irq_a | output | 1 | End-of-sequence flag, sequencer A |
| irq_b | output | 1 | End-of-sequence flag, sequencer B |

## Verification
Two functions can fall in the same cycle: a CPU write to the shared control register, and a hardware change to a pending bit. The bench provokes both orderings. It holds a start write across the grant edge, so that set and clear coincide. It also drives a trigger in the same cycle as a control write whose start bits are 0. In each case it judges the result by counting the conversions that follow, and by reading the pending bit back through the status word.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE   = 2'd0,
    ENG_SAMPLE = 2'd1,
    ENG_LAUNCH = 2'd2,
    ENG_WAIT   = 2'd3
  } eng_state_e;

  // register map (word addresses)
  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_STAT  = 1;
  localparam int ADDR_LEN   = 2;
  localparam int ADDR_ACQ   = 3;
  localparam int ADDR_CHSEL = 4;
  localparam int ADDR_RES   = 16;

  // control word bit positions (two bits each: [A, B])
  localparam int CB_START  = 0;
  localparam int CB_TRIGEN = 2;
  localparam int CB_IRQEN  = 4;
  localparam int CB_CLR    = 6;

  // status word bit positions
  localparam int SB_PEND = 0;
  localparam int SB_FLAG = 2;
  localparam int SB_BUSY = 4;
  localparam int SB_ENG  = 6;

  localparam int LEN_B_LSB = 8;

endpackage

// File: rtl/adcseq_regs.sv
module adcseq_regs
  import adcseq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5,
  parameter int CH_W   = 4,
  parameter int SLOTS  = 8,
  parameter int ACQ_W  = 4,
  localparam int CNT_W     = $clog2(SLOTS),
  localparam int CHAN_BITS = 2 * SLOTS * CH_W
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [1:0]           trig,
  input  logic [1:0]           grant,
  input  logic [1:0]           seq_end,
  input  logic [1:0]           busy_seq,
  input  logic                 eng_busy,
  output logic [1:0]           pend,
  output logic [1:0]           flag,
  output logic [1:0]           trig_en,
  output logic [1:0]           irq_en,
  output logic [CNT_W-1:0]     len_a,
  output logic [CNT_W-1:0]     len_b,
  output logic [ACQ_W-1:0]     acq_len,
  output logic [CHAN_BITS-1:0] chan_map,
  output logic [DATA_W-1:0]    reg_rdata
);

  localparam int SEL_WORDS = (CHAN_BITS + DATA_W - 1) / DATA_W;

  logic                 ctrl_we, len_we, acq_we;
  logic [SEL_WORDS-1:0] sel_we;
  logic [1:0]           cpu_set, hw_set, cpu_clr;
  logic [1:0]           pend_d, flag_d;
  logic [DATA_W-1:0]    sel_q [SEL_WORDS];
  logic [SEL_WORDS*DATA_W-1:0] sel_flat;

  assign ctrl_we = wr_en && (int'(addr) == ADDR_CTRL);
  assign len_we  = wr_en && (int'(addr) == ADDR_LEN);
  assign acq_we  = wr_en && (int'(addr) == ADDR_ACQ);

  // Per-sequencer pending and flag arbitration: any set beats the clear.
  for (genvar g = 0; g < 2; g++) begin : g_seq
    assign cpu_set[g] = ctrl_we & wr_data[CB_START + g];
    assign hw_set[g]  = trig[g] & trig_en[g];
    assign cpu_clr[g] = ctrl_we & wr_data[CB_CLR + g];
    assign pend_d[g]  = (pend[g] & ~grant[g]) | cpu_set[g] | hw_set[g];
    assign flag_d[g]  = (flag[g] & ~cpu_clr[g]) | (seq_end[g] & irq_en[g]);

    p_cpu_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_set[g] |=> pend[g]);
    p_pending_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[g] && !grant[g]) |=> pend[g]);
    p_rise_has_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[g]) |-> $past(cpu_set[g] || hw_set[g]));
    p_flag_on_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_end[g] && irq_en[g]) |=> flag[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= '0;
      flag    <= '0;
      trig_en <= '0;
      irq_en  <= '0;
      len_a   <= '0;
      len_b   <= '0;
      acq_len <= '0;
    end else begin
      pend <= pend_d;
      flag <= flag_d;
      if (ctrl_we) begin
        trig_en <= wr_data[CB_TRIGEN +: 2];
        irq_en  <= wr_data[CB_IRQEN +: 2];
      end
      if (len_we) begin
        len_a <= wr_data[CNT_W-1:0];
        len_b <= wr_data[LEN_B_LSB +: CNT_W];
      end
      if (acq_we) begin
        acq_len <= wr_data[ACQ_W-1:0];
      end
    end
  end

  // Channel-select words, one register per word.
  for (genvar w = 0; w < SEL_WORDS; w++) begin : g_sel
    logic [DATA_W-1:0] word_q;
    assign sel_we[w] = wr_en && (int'(addr) == ADDR_CHSEL + w);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (sel_we[w]) begin
        word_q <= wr_data;
      end
    end
    assign sel_q[w] = word_q;
    assign sel_flat[w*DATA_W +: DATA_W] = word_q;
  end

  assign chan_map = sel_flat[CHAN_BITS-1:0];

  // Read mux; start and clear bits read as zero.
  always_comb begin
    reg_rdata = '0;
    if (int'(addr) == ADDR_CTRL) begin
      reg_rdata[CB_TRIGEN +: 2] = trig_en;
      reg_rdata[CB_IRQEN +: 2]  = irq_en;
    end else if (int'(addr) == ADDR_STAT) begin
      reg_rdata[SB_PEND +: 2] = pend;
      reg_rdata[SB_FLAG +: 2] = flag;
      reg_rdata[SB_BUSY +: 2] = busy_seq;
      reg_rdata[SB_ENG]       = eng_busy;
    end else if (int'(addr) == ADDR_LEN) begin
      reg_rdata[CNT_W-1:0]           = len_a;
      reg_rdata[LEN_B_LSB +: CNT_W]  = len_b;
    end else if (int'(addr) == ADDR_ACQ) begin
      reg_rdata[ACQ_W-1:0] = acq_len;
    end else begin
      for (int w = 0; w < SEL_WORDS; w++) begin
        if (int'(addr) == ADDR_CHSEL + w) reg_rdata = sel_q[w];
      end
    end
  end

endmodule

// File: rtl/adcseq_engine.sv
module adcseq_engine
  import adcseq_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int CH_W  = 4,
  parameter int ACQ_W = 4,
  parameter int RES_W = 12,
  localparam int CNT_W     = $clog2(SLOTS),
  localparam int IDX_W     = CNT_W + 1,
  localparam int CHAN_BITS = 2 * SLOTS * CH_W
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           pend,
  input  logic [CNT_W-1:0]     len_a,
  input  logic [CNT_W-1:0]     len_b,
  input  logic [ACQ_W-1:0]     acq_len,
  input  logic [CHAN_BITS-1:0] chan_map,
  input  logic                 conv_done,
  input  logic [RES_W-1:0]     conv_data,
  output logic [1:0]           grant,
  output logic [1:0]           seq_end,
  output logic [1:0]           busy_seq,
  output logic                 eng_busy,
  output logic                 conv_sample,
  output logic                 conv_start,
  output logic [CH_W-1:0]      conv_chan,
  output logic                 res_we,
  output logic [IDX_W-1:0]     res_idx,
  output logic [RES_W-1:0]     res_data
);

  eng_state_e       state_q, state_d;
  logic             act_q, act_d;
  logic [CNT_W-1:0] slot_q, slot_d;
  logic [ACQ_W-1:0] acq_q, acq_d;
  logic [CNT_W-1:0] last_slot;
  logic             idle, at_last;

  assign idle      = (state_q == ENG_IDLE);
  assign last_slot = act_q ? len_b : len_a;
  assign at_last   = (slot_q == last_slot);

  // fixed priority: sequencer A ahead of B
  assign grant[0] = idle & pend[0];
  assign grant[1] = idle & ~pend[0] & pend[1];

  always_comb begin
    state_d = state_q;
    act_d   = act_q;
    slot_d  = slot_q;
    acq_d   = acq_q;
    case (state_q)
      ENG_IDLE: begin
        if (|grant) begin
          act_d   = grant[1];
          slot_d  = '0;
          acq_d   = '0;
          state_d = ENG_SAMPLE;
        end
      end
      ENG_SAMPLE: begin
        if (acq_q == acq_len) state_d = ENG_LAUNCH;
        else                  acq_d   = acq_q + ACQ_W'(1);
      end
      ENG_LAUNCH: state_d = ENG_WAIT;
      ENG_WAIT: begin
        if (conv_done) begin
          if (at_last) begin
            state_d = ENG_IDLE;
          end else begin
            slot_d  = slot_q + CNT_W'(1);
            acq_d   = '0;
            state_d = ENG_SAMPLE;
          end
        end
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      act_q   <= 1'b0;
      slot_q  <= '0;
      acq_q   <= '0;
    end else begin
      state_q <= state_d;
      act_q   <= act_d;
      slot_q  <= slot_d;
      acq_q   <= acq_d;
    end
  end

  assign eng_busy    = !idle;
  assign busy_seq    = eng_busy ? (act_q ? 2'b10 : 2'b01) : 2'b00;
  assign conv_sample = (state_q == ENG_SAMPLE);
  assign conv_start  = (state_q == ENG_LAUNCH);
  assign res_we      = (state_q == ENG_WAIT) && conv_done;
  assign res_idx     = {act_q, slot_q};
  assign res_data    = conv_data;
  assign conv_chan   = chan_map[res_idx*CH_W +: CH_W];
  assign seq_end     = (res_we && at_last) ? (act_q ? 2'b10 : 2'b01) : 2'b00;

  p_grant_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  p_a_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    grant[1] |-> !pend[0]);
  p_start_after_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(conv_sample));
  p_start_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  p_stop_after_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_end != 2'b00) |=> (!conv_sample && !conv_start));
  p_store_on_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> conv_done);

endmodule

// File: rtl/adcseq_results.sv
module adcseq_results #(
  parameter int NSLOT = 16,
  parameter int RES_W = 12,
  localparam int IDX_W = $clog2(NSLOT)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [RES_W-1:0] wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [RES_W-1:0] rdata
);

  logic [RES_W-1:0] slot_val [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic             hit;
    logic [RES_W-1:0] val_q;
    assign hit = we && (widx == IDX_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
      end else if (hit) begin
        val_q <= wdata;
      end
    end
    assign slot_val[s] = val_q;
  end

  assign rdata = slot_val[ridx];

endmodule

// File: rtl/adc_dualseq_ctrl.sv
module adc_dualseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5,
  parameter int CH_W   = 4,
  parameter int SLOTS  = 8,
  parameter int ACQ_W  = 4,
  parameter int RES_W  = 12
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              trig_a,
  input  logic              trig_b,
  output logic              conv_sample,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  output logic              irq_a,
  output logic              irq_b
);

  localparam int CNT_W     = $clog2(SLOTS);
  localparam int IDX_W     = CNT_W + 1;
  localparam int NSLOT     = 2 * SLOTS;
  localparam int CHAN_BITS = NSLOT * CH_W;

  logic [1:0]           pend, flag, trig_en, irq_en;
  logic [1:0]           grant, seq_end, busy_seq;
  logic                 eng_busy;
  logic [CNT_W-1:0]     len_a, len_b;
  logic [ACQ_W-1:0]     acq_len;
  logic [CHAN_BITS-1:0] chan_map;
  logic [DATA_W-1:0]    cfg_rdata;
  logic                 res_we;
  logic [IDX_W-1:0]     res_widx, res_ridx;
  logic [RES_W-1:0]     res_wdata, res_rdata;
  logic                 is_res;

  adcseq_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CH_W(CH_W), .SLOTS(SLOTS), .ACQ_W(ACQ_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_we), .addr(reg_addr), .wr_data(reg_wdata),
    .trig({trig_b, trig_a}), .grant(grant), .seq_end(seq_end),
    .busy_seq(busy_seq), .eng_busy(eng_busy),
    .pend(pend), .flag(flag), .trig_en(trig_en), .irq_en(irq_en),
    .len_a(len_a), .len_b(len_b), .acq_len(acq_len),
    .chan_map(chan_map), .reg_rdata(cfg_rdata)
  );

  adcseq_engine #(
    .SLOTS(SLOTS), .CH_W(CH_W), .ACQ_W(ACQ_W), .RES_W(RES_W)
  ) u_engine (
    .clk(clk), .rst_n(rst_n),
    .pend(pend), .len_a(len_a), .len_b(len_b), .acq_len(acq_len),
    .chan_map(chan_map), .conv_done(conv_done), .conv_data(conv_data),
    .grant(grant), .seq_end(seq_end), .busy_seq(busy_seq), .eng_busy(eng_busy),
    .conv_sample(conv_sample), .conv_start(conv_start), .conv_chan(conv_chan),
    .res_we(res_we), .res_idx(res_widx), .res_data(res_wdata)
  );

  adcseq_results #(
    .NSLOT(NSLOT), .RES_W(RES_W)
  ) u_results (
    .clk(clk), .rst_n(rst_n),
    .we(res_we), .widx(res_widx), .wdata(res_wdata),
    .ridx(res_ridx), .rdata(res_rdata)
  );

  assign is_res   = (int'(reg_addr) >= ADDR_RES) && (int'(reg_addr) < ADDR_RES + NSLOT);
  assign res_ridx = IDX_W'(reg_addr - ADDR_W'(ADDR_RES));
  assign reg_rdata = is_res ? DATA_W'(res_rdata) : cfg_rdata;

  assign irq_a = flag[0];
  assign irq_b = flag[1];

endmodule

// File: tb/tb_adc_dualseq_ctrl.sv
module tb_adc_dualseq_ctrl;

  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        trig_a = 1'b0, trig_b = 1'b0;
  logic        conv_sample, conv_start;
  logic [3:0]  conv_chan;
  logic        conv_done = 1'b0;
  logic [11:0] conv_data = '0;
  logic        irq_a, irq_b;

  always #5 clk = ~clk;

  adc_dualseq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .trig_a(trig_a), .trig_b(trig_b),
    .conv_sample(conv_sample), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_data(conv_data), .irq_a(irq_a), .irq_b(irq_b)
  );

  int n_tests = 0, n_fail = 0;
  int log_n = 0;
  logic [3:0]  log_chan [512];
  logic [11:0] log_data [512];
  int exp_acq = 0, run_len = 0, cv_cnt = 0;
  logic [11:0] cv_next = '0;
  logic [3:0]  chsel_exp [16];
  int len_exp [2];
  int ctrl_sh = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // converter model and conversion log (negedge, away from the active edge)
  always @(negedge clk) begin
    if (!rst_n) begin
      run_len = 0; cv_cnt = 0; conv_done = 1'b0;
    end else begin
      conv_done = 1'b0;
      if (cv_cnt > 0) begin
        cv_cnt--;
        if (cv_cnt == 0) begin conv_done = 1'b1; conv_data = cv_next; end
      end
      if (conv_sample) run_len++;
      if (conv_start) begin
        chk(run_len == exp_acq + 1, "R7 sample window", run_len, exp_acq + 1);
        cv_next = 12'(log_n * 16 + int'(conv_chan));
        if (log_n < 512) begin
          log_chan[log_n] = conv_chan;
          log_data[log_n] = cv_next;
        end
        log_n++;
        cv_cnt = LAT;
        run_len = 0;
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); we = 1'b1; addr = 5'(a); wdata = 16'(d);
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); addr = 5'(a); #1; v = int'(rdata);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) trig_a = 1'b1; else trig_b = 1'b1;
    @(negedge clk); trig_a = 1'b0; trig_b = 1'b0;
  endtask

  task automatic wait_idle();
    int v;
    for (int i = 0; i < 2000; i++) begin
      rd(1, v);
      if ((v & 'h73) == 0) return;
    end
    chk(1'b0, "R8 return to idle", v, 0);
  endtask

  task automatic program_cfg();
    wr(2, len_exp[0] | (len_exp[1] << 8));
    wr(3, exp_acq);
    for (int w = 0; w < 4; w++)
      wr(4 + w, int'(chsel_exp[4*w]) | (int'(chsel_exp[4*w+1]) << 4) |
                (int'(chsel_exp[4*w+2]) << 8) | (int'(chsel_exp[4*w+3]) << 12));
  endtask

  task automatic check_run(input int base, input int sq);
    int v;
    for (int k = 0; k <= len_exp[sq]; k++) begin
      chk(log_chan[base+k] == chsel_exp[sq*8+k], "R6 channel order",
          int'(log_chan[base+k]), int'(chsel_exp[sq*8+k]));
      rd(16 + sq*8 + k, v);
      chk(v == int'(log_data[base+k]), "R11 stored result", v, int'(log_data[base+k]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog (all requirements): actual 150000 cycles expected fewer");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int v, base;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(1, v);  chk(v == 0, "R1 status after reset", v, 0);
    rd(16, v); chk(v == 0, "R1 result after reset", v, 0);
    chk(!irq_a && !irq_b, "R1 irq after reset", int'({irq_b, irq_a}), 0);
    chk(!conv_sample && !conv_start, "R1 converter idle", int'({conv_start, conv_sample}), 0);

    // directed configuration
    for (int s = 0; s < 16; s++) chsel_exp[s] = 4'(15 - s);
    len_exp[0] = 3; len_exp[1] = 2; exp_acq = 2;
    ctrl_sh = 'h1C;  // trig enables A,B; irq enable A
    wr(0, ctrl_sh);
    program_cfg();

    // R2 software start
    base = log_n;
    wr(0, ctrl_sh | 1);
    rd(0, v); chk((v & 'hC3) == 0, "R2 start/clear bits read 0", v & 'hC3, 0);
    rd(1, v); chk((v & 'h11) != 0, "R2 request visible in status", v, 'h11);
    wait_idle();
    chk(log_n - base == 4, "R6 length A", log_n - base, 4);
    check_run(base, 0);

    // R12 flag
    chk(irq_a == 1'b1, "R12 flag A raised", int'(irq_a), 1);
    chk(irq_b == 1'b0, "R12 flag B quiet", int'(irq_b), 0);
    rd(1, v); chk(v[2] == 1'b1, "R12 status flag A", v, 4);
    wr(0, ctrl_sh | 'h40);
    chk(irq_a == 1'b0, "R12 flag cleared", int'(irq_a), 0);

    // R8 stop after list
    base = log_n;
    repeat (40) @(negedge clk);
    chk(log_n == base, "R8 no conversion while idle", log_n, base);

    // R4 trigger gating
    ctrl_sh = ctrl_sh & ~'h8;
    wr(0, ctrl_sh);
    pulse(1);
    repeat (20) @(negedge clk);
    rd(1, v); chk(v[1] == 1'b0, "R4 disabled trigger ignored", v & 2, 0);
    chk(log_n == base, "R4 no run from disabled trigger", log_n, base);
    ctrl_sh = ctrl_sh | 'h8;
    wr(0, ctrl_sh);
    pulse(1);
    wait_idle();
    chk(log_n - base == 3, "R4 enabled trigger runs B", log_n - base, 3);
    check_run(base, 1);
    chk(irq_b == 1'b0, "R12 flag B with irq disabled", int'(irq_b), 0);

    // R9 priority
    base = log_n;
    wr(0, ctrl_sh | 3);
    wait_idle();
    chk(log_n - base == 7, "R9 both sequences run", log_n - base, 7);
    check_run(base, 0);
    check_run(base + 4, 1);

    // R10 requests while busy collapse to one
    base = log_n;
    wr(0, ctrl_sh | 1);
    for (int i = 0; i < 3; i++) begin
      repeat (2) @(negedge clk);
      pulse(0);
    end
    wait_idle();
    chk(log_n - base == 8, "R10 exactly one extra run", log_n - base, 8);

    // R3 trigger and unrelated CPU write in the same cycle
    base = log_n;
    wr(0, ctrl_sh | 2);
    repeat (2) @(negedge clk);
    @(negedge clk); we = 1'b1; addr = 5'd0; wdata = 16'(ctrl_sh); trig_a = 1'b1;
    @(negedge clk); we = 1'b0; trig_a = 1'b0;
    rd(1, v); chk(v[0] == 1'b1, "R3 pending kept over same-cycle write", v & 1, 1);
    chk(v[5] == 1'b1, "R3 B still busy", (v >> 5) & 1, 1);
    wr(0, ctrl_sh);
    rd(1, v); chk(v[0] == 1'b1, "R3 write of 0 has no effect", v & 1, 1);
    wait_idle();
    chk(log_n - base == 7, "R3 held request serviced", log_n - base, 7);
    check_run(base, 1);
    check_run(base + 3, 0);

    // R5 CPU set coinciding with grant clear
    base = log_n;
    @(negedge clk); we = 1'b1; addr = 5'd0; wdata = 16'(ctrl_sh | 1);
    @(negedge clk);
    @(negedge clk); we = 1'b0;
    wait_idle();
    chk(log_n - base == 8, "R5 set wins over grant clear", log_n - base, 8);

    // R6 boundary lengths: longest A, shortest B, minimal window
    len_exp[0] = 7; len_exp[1] = 0; exp_acq = 0;
    program_cfg();
    base = log_n;
    wr(0, ctrl_sh | 3);
    wait_idle();
    chk(log_n - base == 9, "R6 boundary lengths", log_n - base, 9);
    check_run(base, 0);
    check_run(base + 8, 1);

    // random configurations
    for (int it = 0; it < 8; it++) begin
      int sq, use_trig;
      for (int s = 0; s < 16; s++) chsel_exp[s] = 4'($urandom_range(0, 15));
      len_exp[0] = $urandom_range(0, 7);
      len_exp[1] = $urandom_range(0, 7);
      exp_acq    = $urandom_range(0, 6);
      program_cfg();
      sq = $urandom_range(0, 1);
      use_trig = $urandom_range(0, 1);
      base = log_n;
      if (use_trig != 0) pulse(sq);
      else wr(0, ctrl_sh | (1 << sq));
      wait_idle();
      chk(log_n - base == len_exp[sq] + 1, "R6 random length", log_n - base, len_exp[sq] + 1);
      check_run(base, sq);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule